// File: doc/BRIEF.md
# Posted Store Buffer

This block sits between a processor's store port and a slower external memory bus, both on one clock. A store with a cacheable or bufferable attribute is taken in the cycle it is presented, provided there is room. The block then writes it to the bus later, one word per beat, so the core does not wait for the bus. Storage has two parts: a pool of data words, and a smaller set of address entries. Each entry owns a run of consecutive data words. A store to the word just after the end of the newest entry is added to that entry, so it does not use a new address slot.

Entries leave the block in the order they arrived. Each entry goes out as an incrementing-address burst over a valid/ready bus. A store whose attributes mark it as neither cacheable nor bufferable never enters the storage. It is placed directly on the bus, but only once the block holds nothing, so it cannot overtake older posted writes. An empty output lets a barrier wait until every posted write has completed on the bus.

Top module: `posted_wr_buf`

## Requirements
- R1: The data pool holds at most DWORDS (16) words. A buffered store is refused (stReady low) while all 16 are occupied.
- R2: At most NENT (4) address entries exist at once. A buffered store that needs a new entry is refused while all 4 are in use.
- R3: A buffered store is accepted in the cycle it is presented whenever capacity allows, whatever the state of memReady.
- R4: Attribute encoding: stCache=1 or stBuff=1 marks a store as buffered. stCache=0 together with stBuff=0 marks it non-bufferable.
- R5: A buffered store is appended to the newest entry, using no new address slot, when three conditions hold: at least two entries are present, a data word is free, and stAddr equals the newest entry's base plus its length (modulo 2^AW).
- R6: Entries drain oldest first. Each entry is a burst whose memAddr starts at its base and rises by one per accepted beat. memLast is high on the entry's final word.
- R7: While memReq is high and memReady is low, memAddr, memData and memLast hold their values.
- R8: empty is high exactly when no entry is held.
- R9: A non-bufferable store appears on the bus only when empty is high. It is a single beat with memLast=1, carrying stAddr and stData. stReady equals memReady for it. While the block is not empty, it is refused.
- R10: After reset, empty is high, memReq is low and no word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by core and bus sides |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Core presents a store |
| stAddr | input | AW | Word address of the store |
| stData | input | DW | Store data |
| stCache | input | 1 | Cacheable attribute bit |
| stBuff | input | 1 | Bufferable attribute bit |
| stReady | output | 1 | Store taken this cycle when stValid is high |
| memReq | output | 1 | A beat is offered on the bus |
| memAddr | output | AW | Word address of the beat |
| memData | output | DW | Data of the beat |
| memLast | output | 1 | Final beat of a burst |
| memReady | input | 1 | Bus takes the beat this cycle |
| empty | output | 1 | No posted write outstanding |

## Verification
Two things can happen in the same cycle: a store arriving at the core side and a beat completing on the bus. The case that matters most is an append to the newest entry in the cycle the head entry retires, and an accept in the cycle a word leaves. The bench drives random stores and random memReady together, and about half the store addresses are aimed at the newest entry's next word, so these collisions occur often. A behavioural queue model predicts stReady, every bus field and empty in every cycle, and the bench compares against it. Directed phases cover the cases where the 16th word and the 4th entry are reached, and a non-bufferable store that meets a non-empty buffer.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef struct packed {
    logic pushData;    // write one word into the data pool
    logic pushEntry;   // open a new address entry
    logic appendWord;  // grow the newest entry by one word
    logic popData;     // one word left on the bus
    logic popEntry;    // head entry finished its burst
  } wbufStrb_t;

endpackage

// File: rtl/wbuf_dpath.sv
module wbuf_dpath
  import wbuf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int DWORDS = 16,
  parameter int NENT   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wbufStrb_t                     strb,
  input  logic [AW-1:0]                 stAddr,
  input  logic [DW-1:0]                 stData,
  input  logic [$clog2(DWORDS+1)-1:0]   beatCnt,
  output logic [AW-1:0]                 headAddr,
  output logic [DW-1:0]                 headData,
  output logic [$clog2(DWORDS+1)-1:0]   headLen,
  output logic                          seqHit
);

  localparam int LW = $clog2(DWORDS + 1);
  localparam int DP = (DWORDS > 1) ? $clog2(DWORDS) : 1;
  localparam int EP = (NENT > 1) ? $clog2(NENT) : 1;

  logic [DW-1:0] dataMem [DWORDS];
  logic [AW-1:0] baseMem [NENT];
  logic [LW-1:0] lenMem  [NENT];

  logic [DP-1:0] dWr, dRd;
  logic [EP-1:0] eWr, eRd, eNewest;
  logic [AW-1:0] tailNext;

  function automatic logic [DP-1:0] dInc(input logic [DP-1:0] p);
    return (p == DP'(DWORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [EP-1:0] eInc(input logic [EP-1:0] p);
    return (p == EP'(NENT - 1)) ? '0 : p + 1'b1;
  endfunction

  assign eNewest  = (eWr == '0) ? EP'(NENT - 1) : eWr - 1'b1;
  assign tailNext = baseMem[eNewest] + AW'(lenMem[eNewest]);
  assign seqHit   = (stAddr == tailNext);

  assign headLen  = lenMem[eRd];
  assign headAddr = baseMem[eRd] + AW'(beatCnt);
  assign headData = dataMem[dRd];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dWr <= '0;
      dRd <= '0;
      eWr <= '0;
      eRd <= '0;
    end else begin
      if (strb.pushData)  dWr <= dInc(dWr);
      if (strb.popData)   dRd <= dInc(dRd);
      if (strb.pushEntry) eWr <= eInc(eWr);
      if (strb.popEntry)  eRd <= eInc(eRd);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.pushData) dataMem[dWr] <= stData;
    if (strb.pushEntry) begin
      baseMem[eWr] <= stAddr;
      lenMem[eWr]  <= LW'(1);
    end else if (strb.appendWord) begin
      lenMem[eNewest] <= lenMem[eNewest] + 1'b1;
    end
  end

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DWORDS = 16,
  parameter int NENT   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          stValid,
  input  logic                          stCache,
  input  logic                          stBuff,
  input  logic                          seqHit,
  input  logic [$clog2(DWORDS+1)-1:0]   headLen,
  input  logic                          memReady,
  output wbufStrb_t                     strb,
  output logic [$clog2(DWORDS+1)-1:0]   beatCnt,
  output logic                          stReady,
  output logic                          memReq,
  output logic                          memLast,
  output logic                          bypassSel,
  output logic                          isEmpty
);

  localparam int LW = $clog2(DWORDS + 1);
  localparam int CW = $clog2(NENT + 1);

  logic [CW-1:0] entCnt;
  logic [LW-1:0] dataCnt;
  logic nonBuf, drainValid, drainLast, beatFire;
  logic dataRoom, entRoom, canMerge, canNew, bufAcc;

  assign nonBuf     = !stCache && !stBuff;
  assign isEmpty    = (entCnt == '0);
  assign drainValid = !isEmpty;
  assign drainLast  = (beatCnt == headLen - 1'b1);
  assign bypassSel  = isEmpty && stValid && nonBuf;
  assign beatFire   = drainValid && memReady;

  assign dataRoom = (dataCnt < LW'(DWORDS));
  assign entRoom  = (entCnt < CW'(NENT));
  assign canMerge = (entCnt >= CW'(2)) && seqHit && dataRoom;
  assign canNew   = entRoom && dataRoom;
  assign bufAcc   = stValid && !nonBuf && (canMerge || canNew);

  assign stReady = nonBuf ? (isEmpty && memReady) : (canMerge || canNew);
  assign memReq  = drainValid || bypassSel;
  assign memLast = bypassSel ? 1'b1 : drainLast;

  always_comb begin
    strb            = '0;
    strb.pushData   = bufAcc;
    strb.appendWord = bufAcc && canMerge;
    strb.pushEntry  = bufAcc && !canMerge;
    strb.popData    = beatFire;
    strb.popEntry   = beatFire && drainLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entCnt  <= '0;
      dataCnt <= '0;
      beatCnt <= '0;
    end else begin
      entCnt  <= entCnt + CW'(strb.pushEntry) - CW'(strb.popEntry);
      dataCnt <= dataCnt + LW'(strb.pushData) - LW'(strb.popData);
      if (strb.popEntry)    beatCnt <= '0;
      else if (strb.popData) beatCnt <= beatCnt + 1'b1;
    end
  end

  // R1: a word is never written into a full pool
  p_data_room_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushData |-> (dataCnt < LW'(DWORDS)));

  // R2: an entry is never opened when every slot is taken
  p_entry_room_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushEntry |-> (entCnt < CW'(NENT)));

  // R5: appending leaves the number of entries unchanged
  p_merge_no_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.appendWord && !strb.popEntry) |=> (entCnt == $past(entCnt)));

  // R8: retiring the only entry with nothing new raises empty
  p_empty_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popEntry && entCnt == CW'(1) && !strb.pushEntry) |=> isEmpty);

endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
  import wbuf_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int DWORDS = 16,
  parameter int NENT   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          stCache,
  input  logic          stBuff,
  output logic          stReady,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          memLast,
  input  logic          memReady,
  output logic          empty
);

  localparam int LW = $clog2(DWORDS + 1);

  wbufStrb_t     strb;
  logic [LW-1:0] beatCnt, headLen;
  logic [AW-1:0] headAddr;
  logic [DW-1:0] headData;
  logic          seqHit, bypassSel;

  wbuf_ctrl #(.DWORDS(DWORDS), .NENT(NENT)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stCache(stCache),
    .stBuff(stBuff), .seqHit(seqHit), .headLen(headLen),
    .memReady(memReady), .strb(strb), .beatCnt(beatCnt),
    .stReady(stReady), .memReq(memReq), .memLast(memLast),
    .bypassSel(bypassSel), .isEmpty(empty)
  );

  wbuf_dpath #(.AW(AW), .DW(DW), .DWORDS(DWORDS), .NENT(NENT)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .stAddr(stAddr), .stData(stData),
    .beatCnt(beatCnt), .headAddr(headAddr), .headData(headData),
    .headLen(headLen), .seqHit(seqHit)
  );

  assign memAddr = bypassSel ? stAddr : headAddr;
  assign memData = bypassSel ? stData : headData;

  // R7: a stalled posted beat holds its fields
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !bypassSel) |=>
      (memReq && $stable(memAddr) && $stable(memData) && $stable(memLast)));

  // R6: inside a burst the address steps by one word
  p_burst_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !memLast && !bypassSel) |=>
      (memReq && memAddr == $past(memAddr) + 1'b1));

  // R9: a bypass beat is a single, final beat
  p_bypass_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    bypassSel |-> (memLast && empty));

endmodule

// File: tb/posted_wr_buf_tb.sv
`timescale 1ns/100ps
module posted_wr_buf_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stValid = 1'b0;
  logic [15:0] stAddr = '0;
  logic [31:0] stData = '0;
  logic        stCache = 1'b0;
  logic        stBuff = 1'b0;
  logic        memReady = 1'b0;
  logic        stReady, memReq, memLast, empty;
  logic [15:0] memAddr;
  logic [31:0] memData;

  always #2.5 clk = ~clk;

  posted_wr_buf u_dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr),
    .stData(stData), .stCache(stCache), .stBuff(stBuff),
    .stReady(stReady), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memLast(memLast), .memReady(memReady),
    .empty(empty)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  int baseQ[$];
  int lenQ[$];
  int dataQ[$];
  int beat = 0;
  bit stalledPrev = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int modelTail();
    int n = baseQ.size();
    if (n == 0) return 0;
    return (baseQ[n-1] + lenQ[n-1]) & 16'hFFFF;
  endfunction

  task automatic step(input bit v, input int a, input int d, input bit c,
                      input bit b, input bit r);
    int nE, tail, nD, expA, expD;
    bit isEmp, nb, byp, mrg, nw, expRdy, expReq, expL;
    string tag;
    @(negedge clk);
    stValid = v; stAddr = a[15:0]; stData = d; stCache = c; stBuff = b; memReady = r;
    #1;
    nE = baseQ.size(); nD = dataQ.size();
    isEmp = (nE == 0);
    nb = !c && !b;
    byp = isEmp && v && nb;
    tail = modelTail();
    mrg = (nE >= 2) && ((a & 16'hFFFF) == tail) && (nD < 16);
    nw = (nE < 4) && (nD < 16);
    expRdy = nb ? (isEmp && r) : (mrg || nw);
    if (nb) tag = "R4 R9";
    else if (mrg) tag = "R5";
    else if (nD >= 16) tag = "R1";
    else if (nE >= 4) tag = "R2";
    else tag = "R3";
    check(stReady === expRdy, tag, "stReady", stReady, expRdy);
    check(empty === isEmp, "R8", "empty", empty, isEmp);
    expReq = !isEmp || byp;
    check(memReq === expReq, byp ? "R9" : "R6", "memReq", memReq, expReq);
    if (expReq) begin
      if (byp) begin
        expA = a & 16'hFFFF; expD = d; expL = 1'b1; tag = "R9";
      end else begin
        expA = (baseQ[0] + beat) & 16'hFFFF; expD = dataQ[0];
        expL = (beat == lenQ[0] - 1);
        tag = stalledPrev ? "R7" : "R6";
      end
      check(memAddr === expA[15:0], tag, "memAddr", memAddr, expA);
      check(memData === expD, tag, "memData", memData, expD);
      check(memLast === expL, tag, "memLast", memLast, expL);
    end
    stalledPrev = expReq && !r && !byp;
    // model update: drain first, then store
    if (expReq && r && !byp) begin
      void'(dataQ.pop_front());
      if (beat == lenQ[0] - 1) begin
        void'(baseQ.pop_front());
        void'(lenQ.pop_front());
        beat = 0;
      end else beat++;
    end
    if (v && expRdy && !nb) begin
      if (mrg) lenQ[lenQ.size()-1] = lenQ[lenQ.size()-1] + 1;
      else begin baseQ.push_back(a & 16'hFFFF); lenQ.push_back(1); end
      dataQ.push_back(d);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(empty === 1'b1, "R10", "empty in reset", empty, 1);
    check(memReq === 1'b0, "R10", "memReq in reset", memReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(empty === 1'b1, "R10", "empty after reset", empty, 1);
    check(memReq === 1'b0, "R10", "memReq after reset", memReq, 0);

    // R1 / R5: one short entry, then a 15-word sequential run fills the pool
    step(1, 16'h0100, 32'hA000, 0, 1, 0);
    for (int i = 0; i < 15; i++) step(1, 16'h0200 + i, 32'hB000 + i, 1, 1, 0);
    step(1, 16'h020F, 32'hDEAD, 0, 1, 0);   // sequential but pool full
    step(1, 16'h0300, 32'hBEEF, 1, 0, 0);   // new entry but pool full
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 1);

    // R2: five scattered stores, the fifth is refused
    for (int i = 0; i < 5; i++) step(1, 16'h1000 + 16 * i, 32'hC000 + i, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1);

    // R9: non-bufferable store waits for empty, then goes straight out
    step(1, 16'h2000, 32'h5555, 0, 1, 0);
    step(1, 16'h3000, 32'h7777, 0, 0, 1);
    step(1, 16'h3000, 32'h7777, 0, 0, 0);
    step(1, 16'h3000, 32'h7777, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);

    // mixed random traffic with collisions of accept and drain
    for (int i = 0; i < 6000; i++) begin
      int a, sel;
      bit c, b;
      sel = $urandom_range(0, 99);
      a = (sel < 50) ? modelTail() : $urandom_range(0, 65535);
      c = $urandom_range(0, 1);
      b = ($urandom_range(0, 9) < 8) ? 1'b1 : $urandom_range(0, 1);
      step($urandom_range(0, 3) != 0, a, $urandom, c, b, $urandom_range(0, 2) != 0);
    end
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 1);
    check(empty === 1'b1, "R8", "empty after final drain", empty, 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule